// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block owns the status/control word of a floating-point unit. After every arithmetic operation the unit reports five raw condition bits: invalid, divide-by-zero, overflow, underflow and inexact. The controller rebuilds the sticky-free flag field from them, folds them into an accumulating cause field, and raises a one-cycle exception request carrying a fixed trap vector when an accumulated cause is also enabled. It also takes software writes under a bit mask, and decodes the rounding-mode and denormal-flush controls for the arithmetic unit.

Compares are handled on a separate strobe. An ordered compare only loads the condition bit `tBit` from the compare result and leaves the status word alone. An unordered compare goes through the same status update as an arithmetic operation, using the condition bits presented with it.

Status word layout: rounding mode at bits 1:0 (value 01 = truncate toward zero), flags at bits 6:2, enables at bits 11:7, cause at bits 16:12, denormal-flush control at bit 18. Within each five-bit field the order from low to high is inexact, underflow, overflow, divide-by-zero, invalid, which is also the order of `opExc[0]` to `opExc[4]`. All other bits are reserved and read zero.

Top module: `fpsc_top`

## Requirements
- R1: After reset `statusReg` equals the reset value (zero by default), `tBit` is 0, `excReq` is 0 and `excVector` is 0.
- R2: With `wrEn` high, each bit of `statusReg` whose `wrMask` bit is 1 takes the `wrData` bit on the next edge, other bits hold, and reserved bits (17 and 19 to 31) always read 0.
- R3: An accepted status update clears all five flag bits and sets exactly the flags whose `opExc` bit is 1 (flags bit 2+k follows `opExc[k]`).
- R4: An accepted status update ORs `opExc` into the cause field (cause bit 12+k gets `opExc[k]`); cause bits are never cleared except by a write.
- R5: `excReq` is high for the one cycle after an accepted status update in which `opExc` is nonzero and the updated cause AND the enable field (bits 11:7) is nonzero; the status word changes on that same edge.
- R6: `roundToZero` is 1 exactly when `statusReg[1:0]` is 01; values 00, 10 and 11 give 0 (round to nearest even).
- R7: `flushToZero` equals `statusReg[18]`.
- R8: A compare with `cmpUnordered` low loads `tBit` from `cmpTrue` on the next edge, leaves `statusReg` unchanged and gives no `excReq`, even if `opDone` is also high.
- R9: A compare with `cmpUnordered` high performs the status update of R3 to R5 with `opExc` and leaves `tBit` unchanged.
- R10: When `wrEn` is high in the same cycle as `opDone` or `cmpDone`, only the write takes effect: no flag, cause or `tBit` change and no `excReq` from the operation.
- R11: An accepted status update with `opExc` zero clears the flags, keeps the cause and raises no `excReq`, even when cause AND enable is nonzero.
- R12: `excVector` is 0x120 while `excReq` is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Software write strobe |
| wrMask | input | 32 | Per-bit write enable |
| wrData | input | 32 | Write data |
| opDone | input | 1 | Arithmetic operation completed |
| opExc | input | 5 | Raised conditions: [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow, [0] inexact |
| cmpDone | input | 1 | Compare completed |
| cmpUnordered | input | 1 | Compare result was unordered |
| cmpTrue | input | 1 | Compare condition held (ordered compares) |
| statusReg | output | 32 | Current status/control word |
| tBit | output | 1 | Compare condition bit |
| excReq | output | 1 | One-cycle exception request |
| excVector | output | 12 | Trap vector, valid with excReq |
| roundToZero | output | 1 | Truncation rounding selected |
| flushToZero | output | 1 | Denormal flush selected |

## Verification
A corrupted flag, enable or cause bit is visible on `statusReg` at the first sample after the edge that produced it, and a cause bit lost or kept wrongly shows up later as a missing or spurious `excReq` on the next operation that raises any condition. A wrong priority between write, compare and update shows as a `tBit` or status mismatch in the cycle right after the collision. The bench therefore compares every output against a behavioural model after every edge, so any divergence is reported within one cycle of its cause.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

  localparam int NUM_EXC   = 5;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + NUM_EXC;
  localparam int CAUSE_LSB = EN_LSB + NUM_EXC;
  localparam int DN_BIT    = 18;
  localparam logic [RM_W-1:0] RM_TRUNC = 2'b01;

  typedef struct packed {
    logic doWrite;
    logic doUpdate;
    logic doTset;
    logic raise;
  } fpscStrobe_t;

endpackage

// File: rtl/fpsc_ctrl.sv
module fpsc_ctrl
  import fpsc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               opDone,
  input  logic [NUM_EXC-1:0] opExc,
  input  logic               cmpDone,
  input  logic               cmpUnordered,
  input  logic [NUM_EXC-1:0] causeCur,
  input  logic [NUM_EXC-1:0] enableCur,
  output fpscStrobe_t        strb
);

  logic              statusPath;
  logic [NUM_EXC-1:0] causeNext;

  always_comb begin
    statusPath = cmpDone ? cmpUnordered : opDone;
    causeNext  = causeCur | opExc;

    strb.doWrite  = wrEn;
    strb.doTset   = !wrEn && cmpDone && !cmpUnordered;
    strb.doUpdate = !wrEn && statusPath;
    strb.raise    = strb.doUpdate && (|opExc) && (|(causeNext & enableCur));
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doWrite, strb.doUpdate, strb.doTset})) else $error("action overlap"); // R10

  AST_QUIET_NO_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (opExc == '0) |-> !strb.raise) else $error("raise without condition"); // R11

endmodule

// File: rtl/fpsc_datapath.sv
module fpsc_datapath
  import fpsc_pkg::*;
#(
  parameter int          REG_W     = 32,
  parameter int          VEC_W     = 12,
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120,
  parameter logic [REG_W-1:0] RST_VALUE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  fpscStrobe_t        strb,
  input  logic [REG_W-1:0]   wrMask,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_EXC-1:0] opExc,
  input  logic               cmpTrue,
  output logic [REG_W-1:0]   statusQ,
  output logic               tQ,
  output logic               excReqQ,
  output logic [VEC_W-1:0]   excVector,
  output logic [NUM_EXC-1:0] causeCur,
  output logic [NUM_EXC-1:0] enableCur,
  output logic               roundToZero,
  output logic               flushToZero
);

  localparam int IMPL_TOP = CAUSE_LSB + NUM_EXC;

  logic [REG_W-1:0] implMask;
  logic [REG_W-1:0] updated;
  logic [REG_W-1:0] written;

  for (genvar b = 0; b < REG_W; b++) begin : g_impl
    if (b < IMPL_TOP || b == DN_BIT) begin : g_on
      assign implMask[b] = 1'b1;
    end else begin : g_off
      assign implMask[b] = 1'b0;
    end
  end

  assign causeCur  = statusQ[CAUSE_LSB +: NUM_EXC];
  assign enableCur = statusQ[EN_LSB +: NUM_EXC];

  always_comb begin
    written = ((statusQ & ~wrMask) | (wrData & wrMask)) & implMask;
    updated = statusQ;
    updated[FLAG_LSB +: NUM_EXC]  = opExc;
    updated[CAUSE_LSB +: NUM_EXC] = causeCur | opExc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= RST_VALUE & implMask;
      tQ      <= 1'b0;
      excReqQ <= 1'b0;
    end else begin
      excReqQ <= strb.raise;
      if (strb.doWrite) begin
        statusQ <= written;
      end else if (strb.doUpdate) begin
        statusQ <= updated;
      end
      if (strb.doTset) begin
        tQ <= cmpTrue;
      end
    end
  end

  assign excVector   = excReqQ ? TRAP_VEC : '0;
  assign roundToZero = (statusQ[RM_LSB +: RM_W] == RM_TRUNC);
  assign flushToZero = statusQ[DN_BIT];

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~implMask) == '0) else $error("reserved bit set"); // R2

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doWrite |=> (($past(causeCur) & ~causeCur) == '0)) else $error("cause bit lost"); // R4

  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    excReqQ |-> ((causeCur & enableCur) != '0)) else $error("request without enabled cause"); // R5

  AST_REQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    excReqQ |-> (statusQ[FLAG_LSB +: NUM_EXC] != '0)) else $error("request with clear flags"); // R11

  AST_CMP_ORDERED: assert property (@(posedge clk) disable iff (!rstN)
    strb.doTset |=> (tQ == $past(cmpTrue)) && $stable(statusQ) && !excReqQ) else $error("ordered compare"); // R8

  AST_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    excReqQ |-> (excVector == TRAP_VEC)) else $error("bad vector"); // R12

endmodule

// File: rtl/fpsc_top.sv
module fpsc_top
  import fpsc_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int VEC_W = 12,
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120,
  parameter logic [REG_W-1:0] RST_VALUE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrMask,
  input  logic [REG_W-1:0]   wrData,
  input  logic               opDone,
  input  logic [NUM_EXC-1:0] opExc,
  input  logic               cmpDone,
  input  logic               cmpUnordered,
  input  logic               cmpTrue,
  output logic [REG_W-1:0]   statusReg,
  output logic               tBit,
  output logic               excReq,
  output logic [VEC_W-1:0]   excVector,
  output logic               roundToZero,
  output logic               flushToZero
);

  fpscStrobe_t        strb;
  logic [NUM_EXC-1:0] causeCur;
  logic [NUM_EXC-1:0] enableCur;

  fpsc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .opDone       (opDone),
    .opExc        (opExc),
    .cmpDone      (cmpDone),
    .cmpUnordered (cmpUnordered),
    .causeCur     (causeCur),
    .enableCur    (enableCur),
    .strb         (strb)
  );

  fpsc_datapath #(
    .REG_W     (REG_W),
    .VEC_W     (VEC_W),
    .TRAP_VEC  (TRAP_VEC),
    .RST_VALUE (RST_VALUE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrMask      (wrMask),
    .wrData      (wrData),
    .opExc       (opExc),
    .cmpTrue     (cmpTrue),
    .statusQ     (statusReg),
    .tQ          (tBit),
    .excReqQ     (excReq),
    .excVector   (excVector),
    .causeCur    (causeCur),
    .enableCur   (enableCur),
    .roundToZero (roundToZero),
    .flushToZero (flushToZero)
  );

endmodule

// File: tb/fpsc_top_bench.sv
module fpsc_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrMask = '0;
  logic [31:0] wrData = '0;
  logic        opDone = 1'b0;
  logic [4:0]  opExc = '0;
  logic        cmpDone = 1'b0;
  logic        cmpUnordered = 1'b0;
  logic        cmpTrue = 1'b0;
  logic [31:0] statusReg;
  logic        tBit;
  logic        excReq;
  logic [11:0] excVector;
  logic        roundToZero;
  logic        flushToZero;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mReg = '0;
  logic        mT = 1'b0;
  logic        mReq = 1'b0;
  localparam logic [31:0] IMPL = 32'h0005_FFFF;

  always #10 clk = ~clk;

  fpsc_top u_fpsc_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMask(wrMask), .wrData(wrData),
    .opDone(opDone), .opExc(opExc), .cmpDone(cmpDone), .cmpUnordered(cmpUnordered),
    .cmpTrue(cmpTrue), .statusReg(statusReg), .tBit(tBit), .excReq(excReq),
    .excVector(excVector), .roundToZero(roundToZero), .flushToZero(flushToZero)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "statusReg", statusReg, mReg);
    chk(tag, "tBit", {31'b0, tBit}, {31'b0, mT});
    chk(tag, "excReq", {31'b0, excReq}, {31'b0, mReq});
    chk(tag, "excVector", {20'b0, excVector}, mReq ? 32'h120 : 32'h0);
    chk(tag, "roundToZero", {31'b0, roundToZero}, {31'b0, mReg[1:0] == 2'b01});
    chk(tag, "flushToZero", {31'b0, flushToZero}, {31'b0, mReg[18]});
  endtask

  task automatic step(string tag, bit w, logic [31:0] m, logic [31:0] d,
                      bit od, logic [4:0] ex, bit cd, bit cu, bit ct);
    @(negedge clk);
    wrEn = w; wrMask = m; wrData = d; opDone = od; opExc = ex;
    cmpDone = cd; cmpUnordered = cu; cmpTrue = ct;
    mReq = 1'b0;
    if (w) begin
      mReg = ((mReg & ~m) | (d & m)) & IMPL;
    end else if (cd && !cu) begin
      mT = ct;
    end else if (od || (cd && cu)) begin
      mReg[6:2] = ex;
      mReg[16:12] = mReg[16:12] | ex;
      mReq = (ex != 0) && ((mReg[16:12] & mReg[11:7]) != 0);
    end
    @(posedge clk);
    #5;
    checkAll(tag);
    wrEn = 1'b0; opDone = 1'b0; cmpDone = 1'b0; opExc = '0;
    cmpUnordered = 1'b0; cmpTrue = 1'b0; wrMask = '0; wrData = '0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    checkAll("R1");
    rstN = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);

    step("R2", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    step("R2", 1, 32'h0000_0F0F, 32'h0, 0, 0, 0, 0, 0);
    step("R2", 1, 32'hFFFF_FFFF, 32'h0, 0, 0, 0, 0, 0);
    for (int v = 0; v < 4; v++) step("R6", 1, 32'h3, v, 0, 0, 0, 0, 0);
    step("R7", 1, 32'h0004_0000, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    step("R7", 1, 32'h0004_0000, 32'h0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 5; k++) step("R3", 0, 0, 0, 1, 5'b1 << k, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 5'b10101, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 5'b00010, 0, 0, 0);

    step("R5", 1, 32'h0001_FF80, 32'h0000_0400, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 5'b00001, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 5'b01000, 0, 0, 0);
    step("R12", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 5'b00001, 0, 0, 0);
    step("R11", 0, 0, 0, 1, 5'b00000, 0, 0, 0);

    step("R8", 0, 0, 0, 0, 0, 1, 0, 1);
    step("R8", 0, 0, 0, 1, 5'b11111, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 1, 0, 1);
    step("R9", 0, 0, 0, 0, 5'b10000, 1, 1, 0);
    step("R9", 1, 32'h0001_FF80, 32'h0000_4800, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 5'b10000, 1, 1, 0);

    step("R10", 1, 32'h0000_0003, 32'h1, 1, 5'b01000, 0, 0, 0);
    step("R10", 1, 32'h0000_0000, 32'h0, 0, 0, 1, 0, 0);
    step("R10", 1, 32'h0001_F07C, 32'h0, 0, 5'b10000, 1, 1, 0);
    step("R12", 0, 0, 0, 0, 0, 0, 0, 0);
    finish();
  end

endmodule